// File: doc/BRIEF.md
# Pulse-Synchronised Serial Audio Receiver

This block receives two-channel audio over a three-wire serial link in which the frame sync is a single bit-clock-wide pulse rather than a channel-select level. The link's bit clock, sync and data are all sampled inside the system clock domain. The bit clock is first passed through a synchroniser. A capture tick is then derived from whichever of its edges configuration selects, and the sync and data lines are sampled on that tick.

A sync pulse marks the left sample's most significant bit. The left sample occupies the next channel-length bits. The right sample follows with no gap, and the frame is padded with zeros up to its configured length. Only bit counting separates the two channels. Once the right sample's last bit has arrived, both words are presented at once, left-aligned in 32-bit outputs, together with a one-cycle strobe. A sync pulse that arrives too early, or one that is missing, is flagged as a framing error. A one bit in the padding sets a sticky status flag, which software clears with a clear input.

Top module: `dsp_audio_rx`

## Requirements
- R1: While reset is high and in the cycle after it, out_valid, frame_err and pad_err are 0 and out_left and out_right are zero.
- R2: cfg_fall = 0 samples sync and data on rising bit-clock edges, and cfg_fall = 1 samples them on falling edges. Data that changes on the opposite edge is received without error in both settings.
- R3: A sync value of 1 sampled on a capture edge starts a frame, and the data bit sampled on that same edge is the left sample's MSB. No data is captured before the first sync pulse, and no framing error is raised before it.
- R4: The channel length comes from cfg_len (0 = 16, 1 = 20, 2 = 24, 3 = 32 bits). The right sample's MSB is the bit directly after the left sample's LSB.
- R5: The received samples are left-aligned in out_left and out_right, and every bit below the channel length is 0.
- R6: Two system clocks or more after the capture edge of the right LSB, out_valid pulses high for exactly one cycle while both words update together. The words then hold their value until the next pulse.
- R7: Padding bits are never stored. A padding bit of 1 sets pad_err, which stays set until pad_clr is high. pad_clr takes priority and clears pad_err the following cycle.
- R8: A sync pulse that arrives before the frame length has elapsed raises frame_err for one cycle and restarts the frame at that pulse. An interrupted frame produces no out_valid.
- R9: If no sync pulse is present on the capture edge right after a frame's last bit, frame_err pulses once and the receiver captures nothing until the next sync pulse.
- R10: cfg_frame64 = 0 selects a 32-bit-clock frame and forces a 16-bit channel length whatever cfg_len holds. cfg_frame64 = 1 selects a 64-bit-clock frame.
- R11: A sync pulse on the first capture edge after a full frame begins a new frame with no error, so frames can follow one another with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous to clk |
| fsync_in | input | 1 | One-bit frame sync pulse |
| sdata_in | input | 1 | Serial data, MSB first |
| cfg_frame64 | input | 1 | 0: 32-clock frame, 1: 64-clock frame |
| cfg_len | input | 2 | Channel length code |
| cfg_fall | input | 1 | 0: capture on rising edge, 1: on falling edge |
| pad_clr | input | 1 | Clears the sticky padding error |
| out_valid | output | 1 | One-cycle strobe when a new sample pair is available |
| out_left | output | 32 | Left sample, left-aligned |
| out_right | output | 32 | Right sample, left-aligned |
| frame_err | output | 1 | One-cycle pulse on an early or missing sync |
| pad_err | output | 1 | Sticky flag for a nonzero padding bit |

## Verification
The assertions rely on a bit clock that is at least several system clocks per half period, which means two strobes can never fall in adjacent cycles. They also rely on configuration that stays unchanged for the whole of a frame. The bench holds each bit-clock level for four system clocks. It changes configuration only while reset is held, and it idles the bit clock at the level opposite the capture edge so that a change of polarity cannot produce a false capture tick.

// File: rtl/darx_pkg.sv
package darx_pkg;
  typedef enum logic [1:0] {
    RG_IDLE  = 2'd0,
    RG_LEFT  = 2'd1,
    RG_RIGHT = 2'd2,
    RG_PAD   = 2'd3
  } region_t;

  typedef enum logic [1:0] {
    LEN_16 = 2'd0,
    LEN_20 = 2'd1,
    LEN_24 = 2'd2,
    LEN_32 = 2'd3
  } len_code_t;
endpackage

// File: rtl/darx_edge_sampler.sv
module darx_edge_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_in,
  input  logic fsync_in,
  input  logic sdata_in,
  input  logic cfg_fall,
  output logic tick,
  output logic fs_bit,
  output logic sd_bit
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] chain [SYNC_STAGES];
  logic [NSIG-1:0] synced;
  logic            bclk_prev;
  logic            rise_w;
  logic            fall_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= {sdata_in, fsync_in, bclk_in};
      for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign synced = chain[SYNC_STAGES-1];
  assign rise_w = synced[0] & ~bclk_prev;
  assign fall_w = ~synced[0] & bclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_prev <= 1'b0;
      tick      <= 1'b0;
      fs_bit    <= 1'b0;
      sd_bit    <= 1'b0;
    end else begin
      bclk_prev <= synced[0];
      tick      <= cfg_fall ? fall_w : rise_w;
      fs_bit    <= synced[1];
      sd_bit    <= synced[2];
    end
  end
endmodule

// File: rtl/darx_framer.sv
module darx_framer
  import darx_pkg::*;
#(
  parameter int FRAME_SHORT = 32,
  parameter int FRAME_LONG  = 64,
  parameter int WORD_W      = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick,
  input  logic                       fs_bit,
  input  logic                       cfg_frame64,
  input  logic [1:0]                 cfg_len,
  output logic                       active,
  output logic                       first,
  output region_t                    region,
  output logic [$clog2(WORD_W)-1:0]  ch_idx,
  output logic                       last_right,
  output logic                       frame_err
);
  localparam int CNT_W = $clog2(FRAME_LONG);
  localparam int EXT_W = CNT_W + 1;
  localparam int IDX_W = $clog2(WORD_W);

  logic             locked;
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] last_pos;
  logic             at_end;
  logic [CNT_W-1:0] cur_pos;
  logic [EXT_W-1:0] ext_pos;
  logic [EXT_W-1:0] chan_len;
  logic [EXT_W-1:0] pair_len;
  logic [EXT_W-1:0] idx_ext;

  assign last_pos = cfg_frame64 ? CNT_W'(FRAME_LONG - 1) : CNT_W'(FRAME_SHORT - 1);
  assign at_end   = locked && (pos == last_pos);

  always_comb begin
    if (!cfg_frame64) begin
      chan_len = EXT_W'(16);
    end else begin
      case (len_code_t'(cfg_len))
        LEN_16:  chan_len = EXT_W'(16);
        LEN_20:  chan_len = EXT_W'(20);
        LEN_24:  chan_len = EXT_W'(24);
        default: chan_len = EXT_W'(WORD_W);
      endcase
    end
  end

  assign pair_len = chan_len << 1;
  assign active   = tick && (fs_bit || (locked && !at_end));
  assign first    = tick && fs_bit;
  assign cur_pos  = fs_bit ? '0 : pos + 1'b1;
  assign ext_pos  = {1'b0, cur_pos};

  always_comb begin
    region  = RG_IDLE;
    idx_ext = '0;
    if (active) begin
      if (ext_pos < chan_len) begin
        region  = RG_LEFT;
        idx_ext = ext_pos;
      end else if (ext_pos < pair_len) begin
        region  = RG_RIGHT;
        idx_ext = ext_pos - chan_len;
      end else begin
        region  = RG_PAD;
      end
    end
  end

  assign ch_idx     = idx_ext[IDX_W-1:0];
  assign last_right = (region == RG_RIGHT) && (ext_pos == pair_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked    <= 1'b0;
      pos       <= '0;
      frame_err <= 1'b0;
    end else begin
      frame_err <= 1'b0;
      if (tick) begin
        if (fs_bit) begin
          frame_err <= locked && !at_end;
          locked    <= 1'b1;
          pos       <= '0;
        end else if (locked) begin
          if (at_end) begin
            locked    <= 1'b0;
            frame_err <= 1'b1;
          end else begin
            pos <= pos + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/darx_assembler.sv
module darx_assembler
  import darx_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      active,
  input  logic                      first,
  input  region_t                   region,
  input  logic [$clog2(WORD_W)-1:0] ch_idx,
  input  logic                      last_right,
  input  logic                      sd_bit,
  output logic [WORD_W-1:0]         left_word,
  output logic [WORD_W-1:0]         right_word,
  output logic                      done
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] TOP_BIT = IDX_W'(WORD_W - 1);

  logic [IDX_W-1:0] sel;
  assign sel = TOP_BIT - ch_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_word  <= '0;
      right_word <= '0;
      done       <= 1'b0;
    end else begin
      done <= active && last_right;
      if (first) begin
        left_word               <= '0;
        left_word[WORD_W-1]     <= sd_bit;
        right_word              <= '0;
      end else if (active && region == RG_LEFT) begin
        left_word[sel]  <= sd_bit;
      end else if (active && region == RG_RIGHT) begin
        right_word[sel] <= sd_bit;
      end
    end
  end
endmodule

// File: rtl/dsp_audio_rx.sv
module dsp_audio_rx
  import darx_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int FRAME_SHORT = 32,
  parameter int FRAME_LONG  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_in,
  input  logic              fsync_in,
  input  logic              sdata_in,
  input  logic              cfg_frame64,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_fall,
  input  logic              pad_clr,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_left,
  output logic [WORD_W-1:0] out_right,
  output logic              frame_err,
  output logic              pad_err
);
  localparam int IDX_W = $clog2(WORD_W);

  logic             tick;
  logic             fs_bit;
  logic             sd_bit;
  logic             active;
  logic             first;
  region_t          region;
  logic [IDX_W-1:0] ch_idx;
  logic             last_right;
  logic             err_w;
  logic [WORD_W-1:0] left_w;
  logic [WORD_W-1:0] right_w;
  logic             done;

  darx_edge_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst(rst), .bclk_in(bclk_in), .fsync_in(fsync_in),
    .sdata_in(sdata_in), .cfg_fall(cfg_fall),
    .tick(tick), .fs_bit(fs_bit), .sd_bit(sd_bit)
  );

  darx_framer #(.FRAME_SHORT(FRAME_SHORT), .FRAME_LONG(FRAME_LONG), .WORD_W(WORD_W)) u_frm (
    .clk(clk), .rst(rst), .tick(tick), .fs_bit(fs_bit),
    .cfg_frame64(cfg_frame64), .cfg_len(cfg_len),
    .active(active), .first(first), .region(region), .ch_idx(ch_idx),
    .last_right(last_right), .frame_err(err_w)
  );

  darx_assembler #(.WORD_W(WORD_W)) u_asm (
    .clk(clk), .rst(rst), .active(active), .first(first), .region(region),
    .ch_idx(ch_idx), .last_right(last_right), .sd_bit(sd_bit),
    .left_word(left_w), .right_word(right_w), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
      frame_err <= 1'b0;
      pad_err   <= 1'b0;
    end else begin
      out_valid <= done;
      frame_err <= err_w;
      if (done) begin
        out_left  <= left_w;
        out_right <= right_w;
      end
      if (pad_clr)
        pad_err <= 1'b0;
      else if (active && region == RG_PAD && sd_bit)
        pad_err <= 1'b1;
    end
  end
endmodule

// File: rtl/darx_checks.sv
module darx_checks #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              pad_clr,
  input logic              cfg_frame64,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_left,
  input logic [WORD_W-1:0] out_right,
  input logic              frame_err,
  input logic              pad_err
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !frame_err && !pad_err && out_left == '0 && out_right == '0));

  p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_hold_words_r6: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_left) && $stable(out_right)));

  p_err_no_valid_r8: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> !out_valid);

  p_pad_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (pad_err && !pad_clr) |=> pad_err);

  p_pad_clear_r7: assert property (@(posedge clk) disable iff (rst)
    pad_clr |=> !pad_err);

  p_short_align_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !cfg_frame64) |-> (out_left[15:0] == '0 && out_right[15:0] == '0));
endmodule

bind dsp_audio_rx darx_checks #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .pad_clr(pad_clr), .cfg_frame64(cfg_frame64),
  .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
  .frame_err(frame_err), .pad_err(pad_err)
);

// File: tb/sim_dsp_audio_rx.sv
`timescale 1ns/1ps
module sim_dsp_audio_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk_in = 1'b0;
  logic        fsync_in = 1'b0;
  logic        sdata_in = 1'b0;
  logic        cfg_frame64 = 1'b0;
  logic [1:0]  cfg_len = 2'd0;
  logic        cfg_fall = 1'b0;
  logic        pad_clr = 1'b0;
  logic        out_valid;
  logic [31:0] out_left;
  logic [31:0] out_right;
  logic        frame_err;
  logic        pad_err;

  int checks = 0;
  int fails = 0;
  int vcnt = 0;
  int ecnt = 0;
  int vmulti = 0;
  logic [31:0] got_l = '0;
  logic [31:0] got_r = '0;

  localparam int HALF = 4;

  always #2 clk = ~clk;

  dsp_audio_rx u0 (
    .clk(clk), .rst(rst), .bclk_in(bclk_in), .fsync_in(fsync_in), .sdata_in(sdata_in),
    .cfg_frame64(cfg_frame64), .cfg_len(cfg_len), .cfg_fall(cfg_fall), .pad_clr(pad_clr),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
    .frame_err(frame_err), .pad_err(pad_err)
  );

  logic vprev = 1'b0;
  always @(posedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        vcnt <= vcnt + 1;
        got_l <= out_left;
        got_r <= out_right;
        if (vprev) vmulti <= vmulti + 1;
      end
      if (frame_err) ecnt <= ecnt + 1;
    end
    vprev <= out_valid;
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic f64, input logic [1:0] len, input logic fall);
    @(negedge clk);
    rst = 1'b1;
    cfg_frame64 = f64; cfg_len = len; cfg_fall = fall;
    bclk_in = fall; fsync_in = 1'b0; sdata_in = 1'b0;
    wait_clks(6);
    rst = 1'b0;
    wait_clks(4);
  endtask

  task automatic send_bit(input logic fs, input logic sd);
    bclk_in = cfg_fall;
    fsync_in = fs; sdata_in = sd;
    wait_clks(HALF);
    bclk_in = ~cfg_fall;
    wait_clks(HALF);
  endtask

  task automatic send_frame(input logic [31:0] l, input logic [31:0] r, input int len,
                            input int flen, input int pad_one, input int nbits);
    for (int p = 0; p < nbits; p++) begin
      logic b;
      if (p < len) b = l[len-1-p];
      else if (p < 2*len) b = r[2*len-1-p];
      else b = (p == pad_one);
      send_bit(p == 0, b);
    end
    if (flen < 0) ;
  endtask

  task automatic settle();
    bclk_in = cfg_fall; fsync_in = 1'b0; sdata_in = 1'b0;
    wait_clks(20);
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1; wait_clks(3);
    check("R1", "valid in reset", {31'b0, out_valid}, 32'd0);
    check("R1", "left in reset", out_left, 32'd0);
    check("R1", "errors in reset", {30'b0, frame_err, pad_err}, 32'd0);
    rst = 1'b0; @(negedge clk);
    check("R1", "right after reset", out_right, 32'd0);
  endtask

  task automatic t_no_sync();
    int v0, e0;
    do_reset(1'b0, 2'd0, 1'b0);
    v0 = vcnt; e0 = ecnt;
    for (int i = 0; i < 40; i++) send_bit(1'b0, i[0] ^ i[2]);
    settle();
    check("R3", "no valid before sync", vcnt - v0, 0);
    check("R3", "no error before sync", ecnt - e0, 0);
  endtask

  task automatic t_short_rise();
    int v0, e0;
    do_reset(1'b0, 2'd3, 1'b0);
    v0 = vcnt; e0 = ecnt;
    send_frame(32'h0000A5C3, 32'h00001E0F, 16, 32, -1, 32);
    settle();
    check("R2", "rising valid count", vcnt - v0, 1);
    check("R10", "short frame left forced 16", got_l, 32'hA5C30000);
    check("R5", "short frame right aligned", got_r, 32'h1E0F0000);
    check("R9", "no error on complete frame", ecnt - e0, 0);
  endtask

  task automatic t_long_fall24();
    int v0;
    do_reset(1'b1, 2'd2, 1'b1);
    v0 = vcnt;
    send_frame(32'h00C35A96, 32'h003F0E81, 24, 64, -1, 64);
    settle();
    check("R2", "falling valid count", vcnt - v0, 1);
    check("R4", "24-bit left", got_l, 32'hC35A9600);
    check("R4", "24-bit right follows left", got_r, 32'h3F0E8100);
  endtask

  task automatic t_long32_20();
    do_reset(1'b1, 2'd3, 1'b0);
    send_frame(32'h89ABCDEF, 32'h13579BDF, 32, 64, -1, 64);
    settle();
    check("R4", "32-bit left", got_l, 32'h89ABCDEF);
    check("R4", "32-bit right", got_r, 32'h13579BDF);
    do_reset(1'b1, 2'd1, 1'b1);
    send_frame(32'h000F1E2D, 32'h000A5A5A, 20, 64, -1, 64);
    settle();
    check("R5", "20-bit left low zero", got_l, 32'hF1E2D000);
    check("R5", "20-bit right low zero", got_r, 32'hA5A5A000);
  endtask

  task automatic t_padding();
    do_reset(1'b1, 2'd0, 1'b0);
    send_frame(32'h00001234, 32'h00005678, 16, 64, 40, 64);
    settle();
    check("R7", "pad bit sets flag", {31'b0, pad_err}, 32'd1);
    check("R7", "pad not stored left", got_l, 32'h12340000);
    check("R7", "pad not stored right", got_r, 32'h56780000);
    send_frame(32'h00001111, 32'h00002222, 16, 64, -1, 64);
    settle();
    check("R7", "flag sticky over clean frame", {31'b0, pad_err}, 32'd1);
    @(negedge clk); pad_clr = 1'b1; @(negedge clk); pad_clr = 1'b0;
    check("R7", "flag cleared", {31'b0, pad_err}, 32'd0);
  endtask

  task automatic t_early();
    int v0, e0;
    do_reset(1'b0, 2'd0, 1'b0);
    v0 = vcnt; e0 = ecnt;
    send_frame(32'h0000FFFF, 32'h0000FFFF, 16, 32, -1, 10);
    send_frame(32'h00004321, 32'h00008765, 16, 32, -1, 32);
    settle();
    check("R8", "early sync error count", ecnt - e0, 1);
    check("R8", "only restarted frame valid", vcnt - v0, 1);
    check("R8", "restarted frame left", got_l, 32'h43210000);
  endtask

  task automatic t_missing();
    int v0, e0;
    do_reset(1'b0, 2'd0, 1'b1);
    v0 = vcnt; e0 = ecnt;
    send_frame(32'h0000AAAA, 32'h00005555, 16, 32, -1, 32);
    for (int i = 0; i < 40; i++) send_bit(1'b0, 1'b1);
    settle();
    check("R9", "missing sync error once", ecnt - e0, 1);
    check("R9", "no capture while unlocked", vcnt - v0, 1);
    send_frame(32'h00000F0F, 32'h0000F0F0, 16, 32, -1, 32);
    settle();
    check("R9", "relock on next sync", got_r, 32'hF0F00000);
  endtask

  task automatic t_back_to_back();
    int v0, e0;
    do_reset(1'b0, 2'd0, 1'b0);
    v0 = vcnt; e0 = ecnt;
    send_frame(32'h00000001, 32'h00008000, 16, 32, -1, 32);
    send_frame(32'h0000BEEF, 32'h0000CAFE, 16, 32, -1, 32);
    settle();
    check("R11", "two frames no error", ecnt - e0, 0);
    check("R11", "two strobes", vcnt - v0, 2);
    check("R6", "second pair left", got_l, 32'hBEEF0000);
    check("R6", "second pair right", got_r, 32'hCAFE0000);
    check("R6", "strobe one cycle", vmulti, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_clks(4);
    t_reset();
    t_no_sync();
    t_short_rise();
    t_long_fall24();
    t_long32_20();
    t_padding();
    t_early();
    t_missing();
    t_back_to_back();
    finish_run();
  end
endmodule